// File: doc/BRIEF.md
# Serial-Shared Fixed-Direction Port

This block is an eight-pin general-purpose port on a processor's register bus. Pin direction is set by bit position and cannot be programmed: every even pin drives out and every odd pin is sampled in. Each even pin has a serial transmit line assigned to it, and a per-pin selection decides whether that transmit line or the port's stored output value drives the pin. Software controls the port through two byte registers. One holds the stored output values. The other is write-only and holds the per-pin serial selection.

Reading the data register gives a mixed word. The odd bits are the synchronized input pin levels. The even bits are the value actually on each output buffer, which is the serial transmit line whenever that pin has been handed to its transmitter. Software can therefore see what is really leaving the chip. The stored output values stay writable while a pin is serial-driven, so software can load the value the pin should return to before it takes the pin back.

Top module: `sspt_port`

## Requirements
- R1: Odd pins are never driven: `pin_out` bits 1, 3, 5 and 7 are always 0. A write to the data register stores only its even bits. Its odd bits are discarded and never appear in the readback.
- R2: During reset and after it, the serial selection is all clear and the stored output values are pin0=1, pin2=1, pin4=1, pin6=0. `pin_out` therefore reads 0x15 with all transmit lines low, and a function-register read returns 0x00.
- R3: A bus write (`bus_wr`=1) to offset 0x50 updates the stored even output bits at that clock edge. Every even pin whose serial selection is clear shows the new value right after that edge.
- R4: Writing 1 to function-register bit 6, 4, 2 or 0 hands pin 6, 4, 2 or 0 to `ser_tx[3]`, `ser_tx[2]`, `ser_tx[1]` or `ser_tx[0]` respectively. These are transmitters A, B, C and D. A selected pin follows its transmit line combinationally. A transmit line has no effect on a pin whose selection is clear.
- R5: While a pin is serial-driven, its stored bit is not shown on the pin but can still be written. Clearing the selection makes the pin show the most recently written stored bit.
- R6: A read (`bus_rd`=1) at offset 0x50 returns the value on each even output buffer in the even bits and the synchronized odd pin levels in the odd bits. The even bits of `pin_in` are ignored.
- R7: The function register lives at offset 0x55 and is write-only: a read there returns 0x00. Its odd bits are not stored and have no effect on the pins.
- R8: Writes to any other offset, and writes at 0x50 with `bus_wr` low, change nothing. A read at any other offset, or any cycle with `bus_rd` low, returns 0x00 on `bus_rdata`.
- R9: An odd pin level change first appears in the data-register readback after exactly two rising clock edges. `bus_rdata` is combinational from the address and the register state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` |
| bus_rdata | output | 8 | Read data, 0 when no register is read |
| ser_tx | input | 4 | Serial transmit lines; index k serves pin 2k (3=A, 2=B, 1=C, 0=D) |
| pin_in | input | 8 | Raw pin levels; only the odd bits are used |
| pin_out | output | 8 | Output pin drive; even bits carry data, odd bits are 0 |

## Verification
The checker examines four things on every cycle. Odd pins are never driven. A selected pin follows its transmit line. The even readback bits match the real pin drive. The odd readback bits match the pin levels from two edges earlier. It also confirms that a data write lands on each unselected pin one edge later and that reads of the function register or of unmapped offsets return zero. The remaining properties appear only through scenarios in the bench: the reset values, the exact edge where a synchronized input change appears, a stored value coming back when a selection is cleared, and writes that must have no effect.

// File: rtl/sspt_pkg.sv
package sspt_pkg;

  // Result of decoding the bus offset.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_FUNC = 2'd2
  } sspt_sel_e;

endpackage

// File: rtl/sspt_rst_sync.sv
module sspt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sspt_sync.sv
module sspt_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sspt_regs.sv
module sspt_regs
  import sspt_pkg::*;
#(
  parameter int                  NUM_PAIRS = 4,
  parameter int                  ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]   DATA_OFS  = 8'h50,
  parameter logic [ADDR_W-1:0]   FUNC_OFS  = 8'h55,
  parameter logic [NUM_PAIRS-1:0] RST_DATA = 4'b0111
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [NUM_PAIRS-1:0] wd_even,
  output sspt_sel_e            sel,
  output logic [NUM_PAIRS-1:0] data_q,
  output logic [NUM_PAIRS-1:0] func_q
);

  logic                 data_en;
  logic                 func_en;
  logic [NUM_PAIRS-1:0] data_d;
  logic [NUM_PAIRS-1:0] func_d;

  // Offset decode
  always_comb begin
    if (bus_addr == DATA_OFS) begin
      sel = SEL_DATA;
    end else if (bus_addr == FUNC_OFS) begin
      sel = SEL_FUNC;
    end else begin
      sel = SEL_NONE;
    end
  end

  // Next-state and clock enables
  always_comb begin
    data_en = bus_wr && (sel == SEL_DATA);
    func_en = bus_wr && (sel == SEL_FUNC);
    data_d  = wd_even;
    func_d  = wd_even;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= RST_DATA;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
    end else if (func_en) begin
      func_q <= func_d;
    end
  end

endmodule

// File: rtl/sspt_outmux.sv
module sspt_outmux #(
  parameter int NUM_PAIRS = 4
) (
  input  logic [NUM_PAIRS-1:0] data_q,
  input  logic [NUM_PAIRS-1:0] func_q,
  input  logic [NUM_PAIRS-1:0] ser_tx,
  output logic [NUM_PAIRS-1:0] drv
);

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pin
    always_comb begin
      if (func_q[k]) begin
        drv[k] = ser_tx[k];
      end else begin
        drv[k] = data_q[k];
      end
    end
  end

endmodule

// File: rtl/sspt_port.sv
module sspt_port
  import sspt_pkg::*;
#(
  parameter int                   NUM_PAIRS   = 4,
  parameter int                   ADDR_W      = 8,
  parameter int                   SYNC_STAGES = 2,
  parameter int                   RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0]    DATA_OFS    = 8'h50,
  parameter logic [ADDR_W-1:0]    FUNC_OFS    = 8'h55,
  parameter logic [NUM_PAIRS-1:0] RST_DATA    = 4'b0111,
  localparam int                  PORT_W      = 2 * NUM_PAIRS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PORT_W-1:0]    bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [PORT_W-1:0]    bus_rdata,
  input  logic [NUM_PAIRS-1:0] ser_tx,
  input  logic [PORT_W-1:0]    pin_in,
  output logic [PORT_W-1:0]    pin_out
);

  logic                 rst_sync_n;
  sspt_sel_e            sel;
  logic [NUM_PAIRS-1:0] wd_even;
  logic [NUM_PAIRS-1:0] wd_odd_unused;
  logic [NUM_PAIRS-1:0] pin_odd_raw;
  logic [NUM_PAIRS-1:0] pin_even_unused;
  logic [NUM_PAIRS-1:0] pin_odd_sync;
  logic [NUM_PAIRS-1:0] data_q;
  logic [NUM_PAIRS-1:0] func_q;
  logic [NUM_PAIRS-1:0] drv;
  logic [PORT_W-1:0]    rd_word;

  // Split the byte-wide buses into output and input halves
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_split
    assign wd_even[k]         = bus_wdata[2*k];
    assign wd_odd_unused[k]   = bus_wdata[2*k+1];
    assign pin_odd_raw[k]     = pin_in[2*k+1];
    assign pin_even_unused[k] = pin_in[2*k];
    assign pin_out[2*k]       = drv[k];
    assign pin_out[2*k+1]     = 1'b0;
    assign rd_word[2*k]       = drv[k];
    assign rd_word[2*k+1]     = pin_odd_sync[k];
  end

  sspt_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  sspt_regs #(
    .NUM_PAIRS(NUM_PAIRS),
    .ADDR_W   (ADDR_W),
    .DATA_OFS (DATA_OFS),
    .FUNC_OFS (FUNC_OFS),
    .RST_DATA (RST_DATA)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .wd_even (wd_even),
    .sel     (sel),
    .data_q  (data_q),
    .func_q  (func_q)
  );

  sspt_sync #(
    .WIDTH (NUM_PAIRS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (pin_odd_raw),
    .dout (pin_odd_sync)
  );

  sspt_outmux #(
    .NUM_PAIRS(NUM_PAIRS)
  ) u_outmux (
    .data_q(data_q),
    .func_q(func_q),
    .ser_tx(ser_tx),
    .drv   (drv)
  );

  // Combinational readback; the function register is not readable
  always_comb begin
    if (bus_rd && (sel == SEL_DATA)) begin
      bus_rdata = rd_word;
    end else begin
      bus_rdata = '0;
    end
  end

endmodule

// File: rtl/sspt_port_chk.sv
module sspt_port_chk #(
  parameter int                NUM_PAIRS   = 4,
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_OFS    = 8'h50,
  parameter logic [ADDR_W-1:0] FUNC_OFS    = 8'h55,
  localparam int               PORT_W      = 2 * NUM_PAIRS
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [PORT_W-1:0]    bus_wdata,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [PORT_W-1:0]    bus_rdata,
  input logic [NUM_PAIRS-1:0] ser_tx,
  input logic [PORT_W-1:0]    pin_in,
  input logic [PORT_W-1:0]    pin_out,
  input logic [NUM_PAIRS-1:0] func_q
);

  logic [NUM_PAIRS-1:0] po_even, po_odd, wd_even, rd_even, rd_odd, pin_odd;
  logic [SYNC_STAGES-1:0][NUM_PAIRS-1:0] hist_q;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_cut
    assign po_even[k] = pin_out[2*k];
    assign po_odd[k]  = pin_out[2*k+1];
    assign wd_even[k] = bus_wdata[2*k];
    assign rd_even[k] = bus_rdata[2*k];
    assign rd_odd[k]  = bus_rdata[2*k+1];
    assign pin_odd[k] = pin_in[2*k+1];
  end

  // Delay line of odd pin levels, emptied by reset like the port's
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[SYNC_STAGES-2:0], pin_odd};
    end
  end

  logic rd_data, rd_func, rd_other, wr_data;
  assign rd_data  = bus_rd && (bus_addr == DATA_OFS);
  assign rd_func  = bus_rd && (bus_addr == FUNC_OFS);
  assign rd_other = bus_rd && (bus_addr != DATA_OFS) && (bus_addr != FUNC_OFS);
  assign wr_data  = bus_wr && (bus_addr == DATA_OFS);

  AST_ODD_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    po_odd == '0); // R1

  AST_DATA_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_data |=> (((po_even ^ $past(wd_even)) & ~func_q) == '0)); // R3

  AST_SERIAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((po_even ^ ser_tx) & func_q) == '0); // R4

  AST_READ_EVEN_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data |-> (rd_even == po_even)); // R6

  AST_READ_ODD_SYNC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data |-> (rd_odd == hist_q[SYNC_STAGES-1])); // R9

  AST_FUNC_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_func |-> (bus_rdata == '0)); // R7

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_other || !bus_rd) |-> (bus_rdata == '0)); // R8

endmodule

bind sspt_port sspt_port_chk #(
  .NUM_PAIRS  (NUM_PAIRS),
  .ADDR_W     (ADDR_W),
  .SYNC_STAGES(SYNC_STAGES),
  .DATA_OFS   (DATA_OFS),
  .FUNC_OFS   (FUNC_OFS)
) chk_i (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ser_tx    (ser_tx),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .func_q    (func_q)
);

// File: tb/sspt_port_tb.sv
`timescale 1ns/1ps
module sspt_port_tb_top;

  localparam logic [7:0] A_DATA = 8'h50;
  localparam logic [7:0] A_FUNC = 8'h55;

  logic       clk;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic [3:0] ser_tx;
  logic [7:0] pin_in;
  logic [7:0] pin_out;

  int  checks;
  int  errors;
  bit  done;

  typedef struct {
    string      tag;
    logic [7:0] exp;
    bit         on_pin;
  } exp_t;

  exp_t q[$];
  event smp_ev;

  sspt_port dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .ser_tx   (ser_tx),
    .pin_in   (pin_in),
    .pin_out  (pin_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Monitor: pops the oldest expectation and compares it with the port
  always @(smp_ev) begin
    exp_t       it;
    logic [7:0] act;
    it  = q.pop_front();
    act = it.on_pin ? pin_out : bus_rdata;
    checks++;
    if (act !== it.exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", it.tag,
               it.on_pin ? "pin_out" : "bus_rdata", act, it.exp);
    end
  end

  // Driver side: queue an expectation, then wake the monitor
  task automatic expect_now(input bit on_pin, input logic [7:0] e, input string tag);
    q.push_back('{tag: tag, exp: e, on_pin: on_pin});
    ->smp_ev;
    #1;
  endtask

  task automatic chk_pin(input logic [7:0] e, input string tag);
    #1;
    expect_now(1'b1, e, tag);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
    #1;
    expect_now(1'b0, e, tag);
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    ser_tx = '0; pin_in = '0;
    wait_neg(5);
    rst_n = 1'b1;
    wait_neg(6);

    // Reset state
    chk_pin(8'h15, "R2 reset pin drive");
    rd_chk(A_DATA, 8'h15, "R2 reset data readback");
    rd_chk(A_FUNC, 8'h00, "R2 R7 function read is zero");

    // Plain data writes, odd bits discarded
    wr_reg(A_DATA, 8'hFF); chk_pin(8'h55, "R3 R1 write FF");
    wr_reg(A_DATA, 8'hAA); chk_pin(8'h00, "R1 odd bits discarded");
    rd_chk(A_DATA, 8'h00, "R1 odd write not read back");
    wr_reg(A_DATA, 8'h44); chk_pin(8'h44, "R3 write 44");
    rd_chk(A_DATA, 8'h44, "R6 readback 44");

    // Input synchronizer latency
    @(negedge clk);
    pin_in = 8'hAA; bus_addr = A_DATA; bus_rd = 1'b1;
    #1; expect_now(1'b0, 8'h44, "R9 zero edges");
    @(negedge clk); #1; expect_now(1'b0, 8'h44, "R9 one edge");
    @(negedge clk); #1; expect_now(1'b0, 8'hEE, "R9 two edges");
    wr_reg(A_DATA, 8'h01);
    rd_chk(A_DATA, 8'hAB, "R6 mixed readback");

    // Serial hand-over
    wr_reg(A_FUNC, 8'hFF); chk_pin(8'h00, "R4 all serial tx low");
    ser_tx = 4'b1000; chk_pin(8'h40, "R4 tx A on pin6");
    ser_tx = 4'b0001; chk_pin(8'h01, "R4 tx D on pin0");
    ser_tx = 4'b0101; chk_pin(8'h11, "R4 tx D and B");
    rd_chk(A_DATA, 8'hBB, "R6 readback shows serial drive");
    rd_chk(A_FUNC, 8'h00, "R7 function still reads zero");

    // Stored data writable while serial-driven
    wr_reg(A_DATA, 8'h54); chk_pin(8'h11, "R5 stored bits hidden");
    wr_reg(A_FUNC, 8'h04); chk_pin(8'h50, "R5 only pin2 serial");
    ser_tx = 4'b0111; chk_pin(8'h54, "R4 tx C on pin2");
    ser_tx = 4'b0101; chk_pin(8'h50, "R4 tx C low on pin2");
    wr_reg(A_FUNC, 8'hAA); chk_pin(8'h54, "R7 R5 odd function bits ignored");
    ser_tx = 4'b1111; chk_pin(8'h54, "R4 tx ignored when unselected");

    // Unmapped offsets and missing strobes
    wr_reg(8'h51, 8'h00); chk_pin(8'h54, "R8 write 51 ignored");
    wr_reg(8'h56, 8'h00); chk_pin(8'h54, "R8 write 56 ignored");
    rd_chk(8'h51, 8'h00, "R8 read 51 zero");
    rd_chk(8'h56, 8'h00, "R8 read 56 zero");
    @(negedge clk);
    bus_addr = A_DATA; bus_rd = 1'b0; bus_wdata = 8'h00; bus_wr = 1'b0;
    #1; expect_now(1'b0, 8'h00, "R8 no read strobe");
    @(negedge clk); chk_pin(8'h54, "R8 no write strobe");

    // Even pin levels ignored on readback
    pin_in = 8'h55; wait_neg(3);
    rd_chk(A_DATA, 8'h54, "R6 even pin_in ignored");
    pin_in = 8'hFF; wait_neg(3);
    rd_chk(A_DATA, 8'hFE, "R6 all pins high");

    // Reset in mid-run
    @(negedge clk);
    rst_n = 1'b0; bus_rd = 1'b0;
    chk_pin(8'h15, "R2 asynchronous reset");
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(6);
    chk_pin(8'h15, "R2 function cleared by reset");
    rd_chk(A_DATA, 8'hBF, "R2 R6 readback after reset");

    @(negedge clk);
    bus_rd = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule